// File: doc/BRIEF.md
# Multithreaded Register Rename Unit

This block renames register operands for several hardware threads that run on one core and share a single pool of physical registers. Each thread owns a private table that maps its logical registers to physical tags. A single shared queue of unused physical tags supplies fresh destinations to every thread. Each cycle the front end offers a group of up to three instruction slots from one thread. Each slot carries two logical sources and one logical destination. Within the same cycle the block returns the physical source tags, a newly allocated destination tag, and the tag the destination held before. The back end returns that earlier tag on the free port once the instruction commits.

The group is accepted on a clock edge where `req_valid_i` and `ready_o` are both high. Map-table reads, intra-group forwarding and tag selection are combinational. Only the map tables and the free queue are registers, so every output reflects the state left by the previous accepted group and the previous frees.

Top module: `mt_rename`

## Requirements
- R1: A rename for thread t reads and writes only thread t's map. The other thread's map entries keep their values, so the same logical register in two threads resolves to unrelated physical tags.
- R2: After reset, thread t maps logical register r to physical tag t*32+r, and the free queue holds tags 64..95 in ascending order, with 64 handed out first.
- R3: Each valid slot with its destination bit set receives a distinct tag. Tags are taken from the head of the free queue in slot order (slot 0 first), and slots without a destination consume none. `phys_dst_o` of a slot without a destination reads 0.
- R4: A source that names the logical destination of an earlier slot in the same group receives that slot's new tag. If several earlier slots write it, the nearest one wins.
- R5: `prev_dst_o` of a slot returns the mapping its destination had just before that slot. This is the map entry, or the new tag of an earlier slot in the group that wrote the same register.
- R6: `ready_o` is high exactly when the free queue holds at least as many tags as the group requests destinations. When it is low, nothing is renamed and no map entry or queue entry changes.
- R7: Up to three tags per cycle are accepted on the free port. They are appended behind the queued tags in port order (lane 0 first) and are not allocatable before the following cycle.
- R8: No physical tag is ever held by two live mappings at once, across both threads.
- R9: With `req_valid_i` low, the block changes no map and allocates no tag, whatever the slot inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rename group offered this cycle |
| req_tid_i | input | 1 | Thread of the group |
| slot_vld_i | input | 3 | Per-slot valid |
| slot_has_dst_i | input | 3 | Per-slot destination present |
| slot_src_a_i | input | 3x5 | Logical source A per slot |
| slot_src_b_i | input | 3x5 | Logical source B per slot |
| slot_dst_i | input | 3x5 | Logical destination per slot |
| ready_o | output | 1 | Enough free tags for this group |
| phys_src_a_o | output | 3x7 | Physical source A per slot |
| phys_src_b_o | output | 3x7 | Physical source B per slot |
| phys_dst_o | output | 3x7 | New destination tag per slot |
| prev_dst_o | output | 3x7 | Earlier mapping of the destination per slot |
| free_vld_i | input | 3 | Per-lane free request |
| free_tag_i | input | 3x7 | Tags returned at commit |

## Verification
A corrupted map entry shows up on the next source read of that logical register in that thread, often many cycles after the bad write. For that reason, the bench compares every source against a per-thread reference map on every accepted group. A fault in the free queue produces either a repeated tag, which the live-tag bookkeeping catches on the allocation where it appears, or a tag out of the expected order, which the next destination comparison catches. A wrong count shows up as a `ready_o` mismatch in the first cycle where the demand crosses the true number of free tags. The bench drives this case deliberately by draining the pool.

// File: rtl/mt_rename_pkg.sv
package mt_rename_pkg;
  localparam int unsigned DEF_THREADS = 2;
  localparam int unsigned DEF_LOG_REGS = 32;
  localparam int unsigned DEF_PHYS_REGS = 96;
  localparam int unsigned DEF_WIDTH = 3;
  localparam int unsigned DEF_FREE_W = 3;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_THR = 2,
  parameter int unsigned NUM_LOG = 32,
  parameter int unsigned TAG_W = 7,
  parameter int unsigned NRD = 9,
  parameter int unsigned NWR = 3,
  localparam int unsigned THR_W = mt_rename_pkg::bits_for(NUM_THR),
  localparam int unsigned LOG_W = mt_rename_pkg::bits_for(NUM_LOG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [THR_W-1:0]           rd_tid_i,
  input  logic [NRD-1:0][LOG_W-1:0]  rd_addr_i,
  output logic [NRD-1:0][TAG_W-1:0]  rd_data_o,
  input  logic [THR_W-1:0]           wr_tid_i,
  input  logic [NWR-1:0]             wr_en_i,
  input  logic [NWR-1:0][LOG_W-1:0]  wr_addr_i,
  input  logic [NWR-1:0][TAG_W-1:0]  wr_data_i
);
  logic [NUM_LOG-1:0][TAG_W-1:0] map_q [NUM_THR];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    for (genvar r = 0; r < NUM_LOG; r++) begin : g_ent
      // later write lanes override earlier ones (program order)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          map_q[t][r] <= TAG_W'(t * NUM_LOG + r);
        end else begin
          for (int w = 0; w < NWR; w++) begin
            if (wr_en_i[w] && wr_tid_i == THR_W'(t) && wr_addr_i[w] == LOG_W'(r))
              map_q[t][r] <= wr_data_i[w];
          end
        end
      end
    end

    p_thread_isolated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((|wr_en_i) && wr_tid_i == THR_W'(t)) |=> $stable(map_q[t]));
  end

  always_comb begin
    for (int i = 0; i < NRD; i++) begin
      rd_data_o[i] = '0;
      for (int t = 0; t < NUM_THR; t++)
        if (rd_tid_i == THR_W'(t)) rd_data_o[i] = map_q[t][rd_addr_i[i]];
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned DEPTH = 96,
  parameter int unsigned INIT_BASE = 64,
  parameter int unsigned POP_W = 3,
  parameter int unsigned PUSH_W = 3,
  localparam int unsigned TAG_W = mt_rename_pkg::bits_for(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned INIT_CNT = DEPTH - INIT_BASE
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CNT_W-1:0]             pop_cnt_i,
  output logic [POP_W-1:0][TAG_W-1:0]  head_tags_o,
  output logic [CNT_W-1:0]             count_o,
  input  logic [PUSH_W-1:0]            push_vld_i,
  input  logic [PUSH_W-1:0][TAG_W-1:0] push_tag_i
);
  logic [TAG_W-1:0] fifo_q [DEPTH];
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [PUSH_W-1:0][CNT_W-1:0] push_ofs;
  logic [CNT_W-1:0] push_cnt;

  function automatic logic [TAG_W-1:0] wrap(input logic [TAG_W-1:0] base,
                                            input logic [CNT_W-1:0] ofs);
    logic [TAG_W+CNT_W-1:0] s;
    s = (TAG_W+CNT_W)'(base) + (TAG_W+CNT_W)'(ofs);
    if (s >= (TAG_W+CNT_W)'(DEPTH)) s = s - (TAG_W+CNT_W)'(DEPTH);
    return s[TAG_W-1:0];
  endfunction

  always_comb begin
    push_cnt = '0;
    for (int i = 0; i < PUSH_W; i++) begin
      push_ofs[i] = push_cnt;
      if (push_vld_i[i]) push_cnt = push_cnt + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < POP_W; i++) head_tags_o[i] = fifo_q[wrap(head_q, CNT_W'(i))];
  end
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        fifo_q[i] <= (i < INIT_CNT) ? TAG_W'(INIT_BASE + i) : '0;
      head_q  <= '0;
      tail_q  <= TAG_W'(INIT_CNT % DEPTH);
      count_q <= CNT_W'(INIT_CNT);
    end else begin
      for (int i = 0; i < PUSH_W; i++)
        if (push_vld_i[i]) fifo_q[wrap(tail_q, push_ofs[i])] <= push_tag_i[i];
      head_q  <= wrap(head_q, pop_cnt_i);
      tail_q  <= wrap(tail_q, push_cnt);
      count_q <= count_q - pop_cnt_i + push_cnt;
    end
  end

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_i <= count_q);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/rn_group_bypass.sv
module rn_group_bypass #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LOG_W = 5,
  parameter int unsigned TAG_W = 7
) (
  input  logic [WIDTH-1:0]             slot_vld_i,
  input  logic [WIDTH-1:0]             slot_has_dst_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  src_a_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  src_b_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  dst_i,
  input  logic [WIDTH-1:0][TAG_W-1:0]  new_tag_i,
  input  logic [WIDTH-1:0][TAG_W-1:0]  map_a_i,
  input  logic [WIDTH-1:0][TAG_W-1:0]  map_b_i,
  input  logic [WIDTH-1:0][TAG_W-1:0]  map_d_i,
  output logic [WIDTH-1:0][TAG_W-1:0]  src_a_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  src_b_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  prev_o
);
  // ascending scan: nearest earlier writer wins
  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      src_a_o[k] = map_a_i[k];
      src_b_o[k] = map_b_i[k];
      prev_o[k]  = map_d_i[k];
      for (int j = 0; j < WIDTH; j++) begin
        if (j < k && slot_vld_i[j] && slot_has_dst_i[j]) begin
          if (dst_i[j] == src_a_i[k]) src_a_o[k] = new_tag_i[j];
          if (dst_i[j] == src_b_i[k]) src_b_o[k] = new_tag_i[j];
          if (dst_i[j] == dst_i[k])   prev_o[k]  = new_tag_i[j];
        end
      end
    end
  end
endmodule

// File: rtl/mt_rename.sv
module mt_rename #(
  parameter int unsigned NUM_THR = mt_rename_pkg::DEF_THREADS,
  parameter int unsigned NUM_LOG = mt_rename_pkg::DEF_LOG_REGS,
  parameter int unsigned NUM_PHYS = mt_rename_pkg::DEF_PHYS_REGS,
  parameter int unsigned WIDTH = mt_rename_pkg::DEF_WIDTH,
  parameter int unsigned FREE_W = mt_rename_pkg::DEF_FREE_W,
  localparam int unsigned THR_W = mt_rename_pkg::bits_for(NUM_THR),
  localparam int unsigned LOG_W = mt_rename_pkg::bits_for(NUM_LOG),
  localparam int unsigned TAG_W = mt_rename_pkg::bits_for(NUM_PHYS),
  localparam int unsigned CNT_W = $clog2(NUM_PHYS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [THR_W-1:0]             req_tid_i,
  input  logic [WIDTH-1:0]             slot_vld_i,
  input  logic [WIDTH-1:0]             slot_has_dst_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  slot_src_a_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  slot_src_b_i,
  input  logic [WIDTH-1:0][LOG_W-1:0]  slot_dst_i,
  output logic                         ready_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  phys_src_a_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  phys_src_b_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  phys_dst_o,
  output logic [WIDTH-1:0][TAG_W-1:0]  prev_dst_o,
  input  logic [FREE_W-1:0]            free_vld_i,
  input  logic [FREE_W-1:0][TAG_W-1:0] free_tag_i
);
  localparam int unsigned NRD = 3 * WIDTH;

  logic [WIDTH-1:0]             want_dst;
  logic [WIDTH-1:0][CNT_W-1:0]  dst_ofs;
  logic [CNT_W-1:0]             dst_cnt;
  logic [CNT_W-1:0]             free_cnt;
  logic [WIDTH-1:0][TAG_W-1:0]  alloc_tags;
  logic [WIDTH-1:0][TAG_W-1:0]  new_tag;
  logic [NRD-1:0][LOG_W-1:0]    rd_addr;
  logic [NRD-1:0][TAG_W-1:0]    rd_data;
  logic [WIDTH-1:0][TAG_W-1:0]  map_a, map_b, map_d;
  logic [WIDTH-1:0][TAG_W-1:0]  prev_tag;
  logic                         fire;

  assign want_dst = slot_vld_i & slot_has_dst_i;

  always_comb begin
    dst_cnt = '0;
    for (int k = 0; k < WIDTH; k++) begin
      dst_ofs[k] = dst_cnt;
      if (want_dst[k]) dst_cnt = dst_cnt + 1'b1;
    end
  end

  assign ready_o = free_cnt >= dst_cnt;
  assign fire    = req_valid_i && ready_o;

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      new_tag[k] = alloc_tags[dst_ofs[k]];
      rd_addr[3*k]   = slot_src_a_i[k];
      rd_addr[3*k+1] = slot_src_b_i[k];
      rd_addr[3*k+2] = slot_dst_i[k];
      map_a[k] = rd_data[3*k];
      map_b[k] = rd_data[3*k+1];
      map_d[k] = rd_data[3*k+2];
    end
  end

  rn_free_list #(
    .DEPTH(NUM_PHYS), .INIT_BASE(NUM_THR * NUM_LOG), .POP_W(WIDTH), .PUSH_W(FREE_W)
  ) u_free (
    .clk_i, .rst_ni,
    .pop_cnt_i  (fire ? dst_cnt : '0),
    .head_tags_o(alloc_tags),
    .count_o    (free_cnt),
    .push_vld_i (free_vld_i),
    .push_tag_i (free_tag_i)
  );

  rn_map_table #(
    .NUM_THR(NUM_THR), .NUM_LOG(NUM_LOG), .TAG_W(TAG_W), .NRD(NRD), .NWR(WIDTH)
  ) u_map (
    .clk_i, .rst_ni,
    .rd_tid_i (req_tid_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .wr_tid_i (req_tid_i),
    .wr_en_i  (fire ? want_dst : '0),
    .wr_addr_i(slot_dst_i),
    .wr_data_i(new_tag)
  );

  rn_group_bypass #(.WIDTH(WIDTH), .LOG_W(LOG_W), .TAG_W(TAG_W)) u_byp (
    .slot_vld_i, .slot_has_dst_i,
    .src_a_i(slot_src_a_i), .src_b_i(slot_src_b_i), .dst_i(slot_dst_i),
    .new_tag_i(new_tag),
    .map_a_i(map_a), .map_b_i(map_b), .map_d_i(map_d),
    .src_a_o(phys_src_a_o), .src_b_o(phys_src_b_o), .prev_o(prev_tag)
  );

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      phys_dst_o[k] = want_dst[k] ? new_tag[k] : '0;
      prev_dst_o[k] = prev_tag[k];
    end
  end

  for (genvar j = 0; j < WIDTH; j++) begin : g_uj
    for (genvar k = j + 1; k < WIDTH; k++) begin : g_uk
      p_unique_dst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && want_dst[j] && want_dst[k]) |-> phys_dst_o[j] != phys_dst_o[k]);
    end
  end
endmodule

// File: tb/mt_rename_test.sv
`timescale 1ns/1ps
module mt_rename_test;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [0:0] tid;
  logic [2:0] vld, hd;
  logic [2:0][4:0] sa, sb, sd;
  logic ready;
  logic [2:0][6:0] pa, pb, pd, pp;
  logic [2:0] fv;
  logic [2:0][6:0] ft;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ref_map [2][32];
  int fq[$];
  int retire_q[$];
  bit live [96];

  always #2.5 clk = ~clk;

  mt_rename uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_tid_i(tid),
    .slot_vld_i(vld), .slot_has_dst_i(hd), .slot_src_a_i(sa), .slot_src_b_i(sb),
    .slot_dst_i(sd), .ready_o(ready), .phys_src_a_o(pa), .phys_src_b_o(pb),
    .phys_dst_o(pd), .prev_dst_o(pp), .free_vld_i(fv), .free_tag_i(ft)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; tid = 0; vld = 0; hd = 0; sa = '0; sb = '0; sd = '0; fv = 0; ft = '0;
  endtask

  task automatic pick_frees(input int n);
    for (int i = 0; i < 3; i++) begin
      fv[i] = 0; ft[i] = '0;
      if (i < n && retire_q.size() > 0) begin
        fv[i] = 1; ft[i] = 7'(retire_q.pop_front());
      end
    end
  endtask

  // inputs already set at negedge; check, update model, advance one cycle
  task automatic step(input string tag);
    int tmp [32];
    int n, j, t;
    bit fire, exp_ready, earlier;
    #1;
    for (int r = 0; r < 32; r++) tmp[r] = ref_map[tid][r];
    n = 0;
    for (int k = 0; k < 3; k++) if (vld[k] && hd[k]) n++;
    exp_ready = fq.size() >= n;
    chk(ready == exp_ready, "R6", {tag, " ready"}, int'(ready), int'(exp_ready));
    fire = req_valid && exp_ready;
    j = 0; earlier = 0;
    for (int k = 0; k < 3; k++) begin
      if (vld[k] && (fire || !earlier)) begin
        chk(int'(pa[k]) == tmp[sa[k]], tag, $sformatf("slot%0d src_a", k), int'(pa[k]), tmp[sa[k]]);
        chk(int'(pb[k]) == tmp[sb[k]], tag, $sformatf("slot%0d src_b", k), int'(pb[k]), tmp[sb[k]]);
      end
      if (vld[k] && hd[k]) begin
        earlier = 1;
        if (fire) begin
          chk(int'(pd[k]) == fq[j], "R3", {tag, " new dst"}, int'(pd[k]), fq[j]);
          chk(int'(pp[k]) == tmp[sd[k]], "R5", {tag, " prev dst"}, int'(pp[k]), tmp[sd[k]]);
          retire_q.push_back(tmp[sd[k]]);
          tmp[sd[k]] = fq[j];
          j++;
        end
      end else if (vld[k] && fire) begin
        chk(pd[k] == '0, "R3", {tag, " no-dst slot tag"}, int'(pd[k]), 0);
      end
    end
    if (fire) begin
      for (int r = 0; r < 32; r++) ref_map[tid][r] = tmp[r];
      for (int i = 0; i < j; i++) begin
        t = fq.pop_front();
        chk(!live[t], "R8", "allocated tag already live", t, -1);
        live[t] = 1;
      end
    end
    for (int i = 0; i < 3; i++) if (fv[i]) begin
      fq.push_back(int'(ft[i]));
      live[ft[i]] = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_group(input int t, input logic [2:0] v, input logic [2:0] h, input int range);
    req_valid = 1; tid = 1'(t); vld = v; hd = h;
    for (int k = 0; k < 3; k++) begin
      sa[k] = 5'($urandom % range); sb[k] = 5'($urandom % range); sd[k] = 5'($urandom % range);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    for (int t = 0; t < 2; t++) for (int r = 0; r < 32; r++) ref_map[t][r] = t * 32 + r;
    for (int i = 0; i < 96; i++) live[i] = (i < 64);
    for (int i = 64; i < 96; i++) fq.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2: sweep every reset mapping, both threads
    for (int t = 0; t < 2; t++)
      for (int b = 0; b < 32; b += 3) begin
        idle_inputs(); req_valid = 1; tid = 1'(t); vld = 3'b111;
        for (int k = 0; k < 3; k++) begin
          sa[k] = 5'((b + k) % 32); sb[k] = 5'(31 - ((b + k) % 32));
        end
        step("R2");
      end

    // R3: every destination pattern, thread 0
    for (int p = 0; p < 8; p++) begin
      idle_inputs(); set_group(0, 3'b111, 3'(p), 32); step("R3");
    end
    idle_inputs(); set_group(0, 3'b101, 3'b111, 32); step("R3");

    // R4: intra-group chains in thread 1
    idle_inputs(); set_group(1, 3'b111, 3'b111, 32);
    sd = {5'd5, 5'd5, 5'd5}; sa[1] = 5'd5; sb[2] = 5'd5; sa[2] = 5'd9; step("R4");
    idle_inputs(); set_group(1, 3'b111, 3'b011, 32);
    sd[0] = 5'd3; sd[1] = 5'd4; sa[1] = 5'd3; sa[2] = 5'd4; sb[2] = 5'd3; step("R4");

    // R5: repeated destination in one group
    idle_inputs(); set_group(0, 3'b111, 3'b111, 32); sd = {5'd7, 5'd7, 5'd7}; step("R5");

    // R1: same logical registers in both threads
    for (int i = 0; i < 2; i++)
      for (int t = 0; t < 2; t++) begin
        idle_inputs(); set_group(t, 3'b001, 3'b001, 32); sd[0] = 5'd10; sa[0] = 5'd10; step("R1");
        idle_inputs(); set_group(t, 3'b001, 3'b000, 32); sa[0] = 5'd10; step("R1");
      end

    // R9: invalid group with destinations leaves state alone
    idle_inputs(); set_group(0, 3'b111, 3'b111, 32); req_valid = 0; step("R9");
    idle_inputs(); set_group(0, 3'b111, 3'b001, 32); step("R9");

    // R6: drain the pool
    while (fq.size() >= 3) begin
      idle_inputs(); set_group(1, 3'b111, 3'b111, 32); step("R6");
    end
    idle_inputs(); set_group(1, 3'b111, 3'b111, 32); step("R6");
    while (fq.size() > 0) begin
      idle_inputs(); set_group(1, 3'b001, 3'b001, 32); step("R6");
    end
    idle_inputs(); set_group(0, 3'b010, 3'b010, 32); step("R6");

    // R7: freed tag not usable in the same cycle, usable next
    idle_inputs(); set_group(0, 3'b001, 3'b001, 32); pick_frees(1); step("R7");
    idle_inputs(); set_group(0, 3'b001, 3'b001, 32); step("R7");
    idle_inputs(); pick_frees(3); step("R7");
    idle_inputs(); set_group(1, 3'b111, 3'b111, 32); step("R7");

    // R1/R8: mixed random traffic from both threads
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      set_group($urandom % 2, 3'($urandom), 3'($urandom), ($urandom % 2) ? 4 : 32);
      if ($urandom % 8 == 0) req_valid = 0;
      pick_frees((fq.size() < 6) ? 3 : int'($urandom % 4));
      step("R1");
    end

    idle_inputs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule